// File: doc/BRIEF.md
# Remapping Global Command/Status Unit

This block sits behind the register port of an I/O remapping engine. Software writes a 32-bit global command word that holds four control bits. The block compares each written word with the last one it accepted. From the bits that differ it starts enable or disable operations. A separate one-shot bit asks the engine to take a new remap table pointer from its table address register. When an operation has taken effect, the block reflects it in a companion read-only global status word.

A change of the interrupt-remapping enable is not applied at once. The block raises `busy`, which the interrupt path uses to stop accepting new requests. It then waits until the count of queued in-flight interrupt requests reaches zero. Only at that transaction boundary does it switch the enable and update the status. Command writes that arrive during this window, or while earlier writes are still waiting, go into a small in-order queue. They are executed once the window closes. The command word is write-only: a read at its offset always returns zero, so software polls the status word instead.

Top module: `remap_gcmd_unit`

## Requirements
- R1: After reset, every output is 0 and reads at both the command offset and the status offset return 0.
- R2: The command word is at offset 0x18 and the status word at offset 0x1C. Any read of 0x18 returns 0. The status word is read-only and writes to 0x1C have no effect. Status layout: bit 26 = queued-invalidation on, bit 25 = remapping on, bit 24 = pointer set, bit 23 = compatibility pass-through on. All other status bits read as 0.
- R3: Command bit 26 (1 = enable, 0 = disable) drives `qinv_en`. The output and status bit 26 both take the new value at the clock edge that accepts the command.
- R4: When an accepted command changes bit 25, `busy` is 1 from the accepting edge onward. At the first later edge where `inflight_cnt` is 0, `remap_en` and status bit 25 take the new value and `busy` returns to 0. Before that edge, `remap_en` does not change.
- R5: Command bit 24 written as 1 gives a one-cycle `ptr_latch` pulse in the cycle after the accepting edge, and status bit 24 is set at that same edge. Bit 24 written as 0 has no effect.
- R6: Status bit 24 clears at the edge where a remapping disable completes.
- R7: Command bit 23 is stored at the accepting edge and appears in status bit 23. `cfi_pass` is 1 only while that stored bit, `remap_en` and `legacy_mode` are all 1.
- R8: An accepted command whose bits 26, 25 and 23 equal the previously accepted values starts no operation. `busy` stays 0 and those status bits do not change.
- R9: A command write that arrives while `busy` is 1, or while the queue holds entries, is queued in arrival order up to QDEPTH entries. Queued commands execute one per cycle, starting the cycle after `busy` falls. A write that arrives while the queue is full is dropped.
- R10: A command that turns bit 25 from 0 to 1 while status bit 24 is 0, and does not itself set bit 24, is still carried out and sets `ptr_err`. `ptr_err` clears when a command with bit 24 = 1 is accepted.
- R11: Command bits 31:27 and 22:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| inflight_cnt | input | INFL_W | Number of queued in-flight interrupt requests |
| legacy_mode | input | 1 | Legacy interrupt mode active |
| qinv_en | output | 1 | Queued invalidation enabled |
| remap_en | output | 1 | Interrupt remapping enabled |
| cfi_pass | output | 1 | Compatibility-format interrupts pass through unremapped |
| ptr_latch | output | 1 | One-cycle strobe: take remap table pointer from the address register |
| busy | output | 1 | Remapping switch pending drain; stall new interrupt acceptance |
| ptr_err | output | 1 | Remapping was enabled with no table pointer set |

## Verification
The assertions assume three things about the inputs. First, `inflight_cnt` counts down to zero in finite time once `busy` stalls new requests. Second, a write is a single-cycle `bus_wr` pulse. Third, reset starts low at time zero. The bench honours all three. It holds `inflight_cnt` at a nonzero value for a chosen number of cycles and then drops it to zero. It drives each write for exactly one cycle on the falling edge. It keeps `rst_n` low across the first edges. To fill the queue, the bench holds a drain open on purpose and writes into it. Otherwise every sweep command is issued only after the previous one has fully completed, so the bench model can track state one write at a time.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;

  localparam int QIE_BIT   = 26;
  localparam int IRE_BIT   = 25;
  localparam int SPTR_BIT  = 24;
  localparam int CFI_BIT   = 23;

  typedef struct packed {
    logic qie;
    logic ire;
    logic sptr;
    logic cfi;
  } gcmd_t;

  localparam int GCMD_W = $bits(gcmd_t);

endpackage

// File: rtl/gcmd_fifo.sv
module gcmd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);

endmodule

// File: rtl/gcmd_drain_ctl.sv
module gcmd_drain_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic target,
  input  logic inflight_zero,
  output logic busy,
  output logic remap_en,
  output logic clear_ptr
);
  logic busy_q, busy_d;
  logic en_q, en_d;
  logic tgt_q, tgt_d;
  logic done;

  always_comb begin
    busy_d = busy_q;
    en_d   = en_q;
    tgt_d  = tgt_q;
    done   = 1'b0;
    if (busy_q) begin
      if (inflight_zero) begin
        busy_d = 1'b0;
        en_d   = tgt_q;
        done   = 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      tgt_d  = target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      tgt_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      en_q   <= en_d;
      tgt_q  <= tgt_d;
    end
  end

  assign busy      = busy_q;
  assign remap_en  = en_q;
  assign clear_ptr = done && !tgt_q;

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  assert_switch_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> ($past(busy_q) && $past(inflight_zero)));
  assert_busy_ends_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(inflight_zero));

endmodule

// File: rtl/remap_gcmd_unit.sv
module remap_gcmd_unit
  import gcmd_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          INFL_W  = 6,
  parameter int          QDEPTH  = 4,
  parameter logic [ADDR_W-1:0] CMD_OFF = ADDR_W'(8'h18),
  parameter logic [ADDR_W-1:0] STS_OFF = ADDR_W'(8'h1C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [INFL_W-1:0] inflight_cnt,
  input  logic              legacy_mode,
  output logic              qinv_en,
  output logic              remap_en,
  output logic              cfi_pass,
  output logic              ptr_latch,
  output logic              busy,
  output logic              ptr_err
);
  gcmd_t bus_cmd, fifo_cmd, exec_cmd;
  logic  cmd_wr, exec_valid, ire_change, push, pop;
  logic  fifo_empty, fifo_full, clear_ptr, inflight_zero;
  logic  qie_q, qie_d, cfi_q, cfi_d, ire_sh_q, ire_sh_d;
  logic  psts_q, psts_d, pulse_q, pulse_d, err_q, err_d;
  logic  unused_rsvd;

  assign bus_cmd = '{qie:  bus_wdata[QIE_BIT],  ire: bus_wdata[IRE_BIT],
                     sptr: bus_wdata[SPTR_BIT], cfi: bus_wdata[CFI_BIT]};
  assign unused_rsvd = ^{bus_wdata[31:27], bus_wdata[22:0], fifo_full};

  assign cmd_wr        = bus_wr && (bus_addr == CMD_OFF);
  assign inflight_zero = (inflight_cnt == '0);
  assign pop           = !busy && !fifo_empty;
  assign push          = cmd_wr && (busy || !fifo_empty);
  assign exec_valid    = pop || (!busy && fifo_empty && cmd_wr);
  assign exec_cmd      = fifo_empty ? bus_cmd : fifo_cmd;
  assign ire_change    = exec_valid && (exec_cmd.ire != ire_sh_q);

  gcmd_fifo #(.DEPTH(QDEPTH), .W(GCMD_W)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (bus_cmd),
    .pop   (pop),
    .dout  (fifo_cmd),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  gcmd_drain_ctl u_drain (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (ire_change),
    .target        (exec_cmd.ire),
    .inflight_zero (inflight_zero),
    .busy          (busy),
    .remap_en      (remap_en),
    .clear_ptr     (clear_ptr)
  );

  always_comb begin
    qie_d    = qie_q;
    cfi_d    = cfi_q;
    ire_sh_d = ire_sh_q;
    psts_d   = psts_q;
    err_d    = err_q;
    pulse_d  = 1'b0;
    if (exec_valid) begin
      qie_d    = exec_cmd.qie;
      cfi_d    = exec_cmd.cfi;
      ire_sh_d = exec_cmd.ire;
      pulse_d  = exec_cmd.sptr;
      if (exec_cmd.sptr) begin
        psts_d = 1'b1;
        err_d  = 1'b0;
      end else if (ire_change && exec_cmd.ire && !psts_q) begin
        err_d  = 1'b1;
      end
    end
    if (clear_ptr) psts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qie_q    <= 1'b0;
      cfi_q    <= 1'b0;
      ire_sh_q <= 1'b0;
      psts_q   <= 1'b0;
      pulse_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      qie_q    <= qie_d;
      cfi_q    <= cfi_d;
      ire_sh_q <= ire_sh_d;
      psts_q   <= psts_d;
      pulse_q  <= pulse_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STS_OFF) begin
      bus_rdata[QIE_BIT]  = qie_q;
      bus_rdata[IRE_BIT]  = remap_en;
      bus_rdata[SPTR_BIT] = psts_q;
      bus_rdata[CFI_BIT]  = cfi_q;
    end
  end

  assign qinv_en   = qie_q;
  assign cfi_pass  = cfi_q && remap_en && legacy_mode;
  assign ptr_latch = pulse_q;
  assign ptr_err   = err_q;

  assert_ptr_pulse_sts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_latch |-> psts_q);
  assert_err_with_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptr_err) |-> busy);
  assert_qie_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_valid |=> $stable(qinv_en));
  assert_same_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && (exec_cmd.ire == ire_sh_q)) |=> !busy);

endmodule

// File: tb/tb_remap_gcmd_unit.sv
module tb_remap_gcmd_unit;
  localparam logic [7:0] CMD = 8'h18;
  localparam logic [7:0] STS = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  inflight_cnt;
  logic        legacy_mode;
  logic        qinv_en, remap_en, cfi_pass, ptr_latch, busy, ptr_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit m_qie, m_ire, m_ptr, m_cfi, m_err;

  always #5 clk = ~clk;

  remap_gcmd_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inflight_cnt(inflight_cnt),
    .legacy_mode(legacy_mode), .qinv_en(qinv_en), .remap_en(remap_en),
    .cfi_pass(cfi_pass), .ptr_latch(ptr_latch), .busy(busy), .ptr_err(ptr_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_sts();
    return {5'b0, m_qie, m_ire, m_ptr, m_cfi, 23'b0};
  endfunction

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic out_chk();
    chk(qinv_en == m_qie, "R3 qinv_en", 32'(qinv_en), 32'(m_qie));
    chk(remap_en == m_ire, "R4 remap_en", 32'(remap_en), 32'(m_ire));
    chk(ptr_err == m_err, "R10 ptr_err", 32'(ptr_err), 32'(m_err));
    chk(cfi_pass == (m_cfi & m_ire & legacy_mode), "R7 cfi_pass", 32'(cfi_pass),
        32'(m_cfi & m_ire & legacy_mode));
    read_chk(STS, exp_sts(), "R2 status word");
  endtask

  task automatic do_cmd(input logic [31:0] w, input int hold);
    bit chg;
    @(negedge clk);
    inflight_cnt = (hold > 0) ? 6'd3 : 6'd0;
    bus_addr = CMD; bus_wdata = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chg = (w[25] != m_ire);
    if (w[24]) m_err = 1'b0;
    else if (chg && w[25] && !m_ptr) m_err = 1'b1;
    m_qie = w[26]; m_cfi = w[23];
    if (w[24]) m_ptr = 1'b1;
    chk(ptr_latch == w[24], "R5 ptr_latch pulse", 32'(ptr_latch), 32'(w[24]));
    chk(busy == chg, "R8 busy after accept", 32'(busy), 32'(chg));
    out_chk();
    read_chk(CMD, 32'h0, "R2 command reads zero");
    if (chg) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(busy == 1'b1, "R4 busy held while draining", 32'(busy), 32'h1);
        chk(remap_en == m_ire, "R4 no switch before drain", 32'(remap_en), 32'(m_ire));
      end
      inflight_cnt = 6'd0;
      @(negedge clk);
      m_ire = w[25];
      if (!w[25]) m_ptr = 1'b0;
      chk(busy == 1'b0, "R4 busy clears on drain", 32'(busy), 32'h0);
      chk(ptr_latch == 1'b0, "R5 pulse one cycle", 32'(ptr_latch), 32'h0);
      out_chk();
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = CMD; bus_wr = 1'b0; bus_wdata = '0;
    inflight_cnt = '0; legacy_mode = 1'b1;
    {m_qie, m_ire, m_ptr, m_cfi, m_err} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({qinv_en, remap_en, cfi_pass, ptr_latch, busy, ptr_err} == 6'b0, "R1 reset outputs",
        32'({qinv_en, remap_en, cfi_pass, ptr_latch, busy, ptr_err}), 32'h0);
    read_chk(STS, 32'h0, "R1 reset status");
    read_chk(CMD, 32'h0, "R1 reset command read");

    // R3 R4 R5 R6 R7 R8 R10 R11: every pair of 4-bit command values, reserved bits scrambled
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_cmd({5'h1F & 5'(a * 7), 4'(a), 23'(a * 32'h2F13B)}, (a + b) % 3);
        do_cmd({5'(b), 4'(b), 23'(b * 32'h51A07)}, (a + 2 * b) % 4);
      end
    end

    // R7: legacy mode off blocks pass-through
    do_cmd(32'h0380_0000, 0);
    legacy_mode = 1'b0;
    #1;
    chk(cfi_pass == 1'b0, "R7 legacy off", 32'(cfi_pass), 32'h0);
    legacy_mode = 1'b1;
    #1;
    chk(cfi_pass == 1'b1, "R7 legacy on", 32'(cfi_pass), 32'h1);

    // R2: writes to the status offset are ignored
    @(negedge clk);
    bus_addr = STS; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(busy == 1'b0 && ptr_latch == 1'b0, "R2 status write ignored", 32'({busy, ptr_latch}), 32'h0);
    out_chk();

    // R9: queue in order while draining, overflow dropped
    do_cmd(32'h0, 0);
    @(negedge clk);
    inflight_cnt = 6'd3; bus_addr = CMD; bus_wdata = 32'h0300_0000; bus_wr = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      bus_wdata = {5'b0, 1'(~k[0]), 2'b10, 24'h0};
      chk(qinv_en == 1'b0, "R9 queued write held", 32'(qinv_en), 32'h0);
    end
    @(negedge clk);
    bus_wr = 1'b0;
    chk(busy == 1'b1 && qinv_en == 1'b0, "R9 held while busy", 32'({busy, qinv_en}), 32'h2);
    inflight_cnt = 6'd0;
    @(negedge clk);
    chk(busy == 1'b0 && remap_en == 1'b1, "R9 drain done", 32'({busy, remap_en}), 32'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(qinv_en == 1'(~k[0]), "R9 in-order pop", 32'(qinv_en), 32'(~k[0] & 1));
    end
    @(negedge clk);
    m_qie = 1'b0; m_ire = 1'b1; m_ptr = 1'b1; m_cfi = 1'b0; m_err = 1'b0;
    chk(qinv_en == 1'b0, "R9 fifth write dropped", 32'(qinv_en), 32'h0);
    out_chk();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule